// File: doc/BRIEF.md
# Gated Serial Clock Generator

This block derives the clock for an external serial flash bus from the controller clock. A two-bit select picks a power-of-two divide ratio from 1 to 8, and a phase bit can shift the divided clock by a quarter of its period. Two separate enable bits feed a gate: one is used in normal operation and one during start-up from flash. The serial clock runs while either bit is set.

When both enables are cleared, the generator does not cut the clock at once. It finishes the current serial period and parks the clock low. Only then does it raise a stopped status. A registered copy of the sequencer's idle flag and a combined configuration-safe flag let software tell when the divider, phase and other bus settings may be rewritten. Divider and phase settings are sampled only while the clock is parked, so a write made while the clock runs waits until the next stop/start cycle.

Top module: `sclk_gen`

## Requirements
- R1: After a synchronous reset, `sclk` is 0, `clk_stopped` is 1, and `idle_stat` and `cfg_safe` are 0.
- R2: Setting either `run_en` or `boot_en` while stopped starts the clock at the next rising edge. `clk_stopped` still reads 1 after that edge and reads 0 after the following one.
- R3: While running, the clock keeps running as long as at least one of `run_en` and `boot_en` is 1. It stops only after both are 0.
- R4: With `div_sel` = 1, 2 or 3 (divide by N = 2, 4 or 8) and `phase_sel` = 0, `sclk` is low for the first N/2 controller cycles after the start edge and high for the next N/2. This repeats with period N.
- R5: With `div_sel` = 0 (divide by 1), `sclk` equals the controller clock while running. The gate opens and closes only while the controller clock is low, whatever the value of `phase_sel`.
- R6: `phase_sel` = 1 shifts the serial clock by a quarter period. With divide by 4 or 8, the high window starts N/4 controller cycles earlier than with `phase_sel` = 0. With divide by 2, the waveform is delayed by half a controller cycle.
- R7: After both enables drop, the current serial period completes. The clock parks low at the edge that ends the period, and `clk_stopped` rises one cycle later.
- R8: A change to `div_sel` or `phase_sel` while running has no effect on `sclk`. The new setting applies from the next start.
- R9: `idle_stat` is `eng_idle` delayed by one controller cycle.
- R10: `cfg_safe` is 1 exactly when `clk_stopped` is 1, `idle_stat` is 1 and `xfer_busy`, registered one cycle, is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Clock enable for normal operation |
| boot_en | input | 1 | Clock enable for start-up operation |
| div_sel | input | 2 | Divide select: 0 = /1, 1 = /2, 2 = /4, 3 = /8 |
| phase_sel | input | 1 | 0 = base phase, 1 = quarter-period shift |
| eng_idle | input | 1 | Serial engine idle indication |
| xfer_busy | input | 1 | Bus read or write in progress |
| sclk | output | 1 | Gated serial clock |
| clk_stopped | output | 1 | Serial clock is parked |
| idle_stat | output | 1 | Registered engine idle status |
| cfg_safe | output | 1 | Reconfiguration is permitted |

## Verification
On every cycle, the assertions check five things:
- A running clock survives while any enable is held, and a stopped one starts when an enable appears.
- Stops happen only on the last count of a period.
- The divide count stays within its ratio.
- The latched setting holds steady while running.
- A parked clock shows a zero count and a low divided output.

Only the directed scenarios can show the actual waveform shapes:
- The high and low run lengths for each ratio.
- The quarter-period shifts, including the half-cycle one sampled between rising edges.
- Pass-through of the controller clock at divide by 1.
- The exact cycles on which the status bits change.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int DIV_SEL_W = 2;
    localparam int MAX_LOG   = (1 << DIV_SEL_W) - 1;
    localparam int CNT_W     = (MAX_LOG > 0) ? MAX_LOG : 1;

    localparam logic [DIV_SEL_W-1:0] DIV_BYPASS = '0;
    localparam logic [DIV_SEL_W-1:0] DIV_TWO    = DIV_SEL_W'(1);

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic [DIV_SEL_W-1:0] div;
        logic                 ph;
    } clk_cfg_t;

    typedef logic [CNT_W-1:0] cnt_t;

    // Final count value of one serial period for a given divide select.
    function automatic cnt_t last_cnt(input logic [DIV_SEL_W-1:0] div);
        int n;
        n = 1 << div;
        return cnt_t'(n - 1);
    endfunction

    // High window of the divided clock at a given count.
    function automatic logic high_win(input cnt_t cnt, input clk_cfg_t cfg);
        int n;
        int v;
        n = 1 << cfg.div;
        v = int'(cnt);
        if (cfg.div == DIV_BYPASS) return 1'b0;
        if (cfg.ph) v = (v + n / 4) % n;
        return (v >= n / 2);
    endfunction

endpackage

// File: rtl/sclk_seq.sv
module sclk_seq
    import sclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_req,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 phase_sel,
    output clk_cfg_t             cfg_q,
    output clk_cfg_t             cfg_d,
    output cnt_t                 cnt_q,
    output cnt_t                 cnt_d,
    output logic                 running_q,
    output logic                 running_d
);

    run_state_t st_q;
    run_state_t st_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cfg_d = cfg_q;
        unique case (st_q)
            ST_STOP: begin
                // settings are only sampled while parked
                cfg_d = '{div: div_sel, ph: phase_sel};
                cnt_d = '0;
                if (run_req) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_q == last_cnt(cfg_q.div)) begin
                    cnt_d = '0;
                    if (!run_req) st_d = ST_STOP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
            cfg_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cfg_q <= cfg_d;
        end
    end

    assign running_q = (st_q == ST_RUN);
    assign running_d = (st_d == ST_RUN);

endmodule

// File: rtl/sclk_shape.sv
module sclk_shape
    import sclk_pkg::*;
#(
    parameter bit HALF_SHIFT_EN = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     running_q,
    input  logic     running_d,
    input  clk_cfg_t cfg_q,
    input  clk_cfg_t cfg_d,
    input  cnt_t     cnt_d,
    output logic     base_q,
    output logic     sclk
);

    logic pass_q;
    logic late_q;
    logic use_late;

    // divided clock, registered so it cannot glitch
    always_ff @(posedge clk) begin
        if (rst) base_q <= 1'b0;
        else     base_q <= running_d & high_win(cnt_d, cfg_d);
    end

    // bypass gate changes only while clk is low
    always_ff @(negedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= running_q;
    end

    generate
        if (HALF_SHIFT_EN) begin : g_half
            always_ff @(negedge clk) begin
                if (rst) late_q <= 1'b0;
                else     late_q <= base_q;
            end
        end else begin : g_no_half
            assign late_q = base_q;
        end
    endgenerate

    assign use_late = HALF_SHIFT_EN && (cfg_q.div == DIV_TWO) && cfg_q.ph;

    always_comb begin
        if (cfg_q.div == DIV_BYPASS) sclk = clk & pass_q;
        else if (use_late)           sclk = late_q;
        else                         sclk = base_q;
    end

endmodule

// File: rtl/sclk_status.sv
module sclk_status (
    input  logic clk,
    input  logic rst,
    input  logic running_q,
    input  logic eng_idle,
    input  logic xfer_busy,
    output logic clk_stopped,
    output logic idle_stat,
    output logic cfg_safe
);

    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_stopped <= 1'b1;
            idle_stat   <= 1'b0;
            busy_q      <= 1'b0;
        end else begin
            clk_stopped <= !running_q;
            idle_stat   <= eng_idle;
            busy_q      <= xfer_busy;
        end
    end

    assign cfg_safe = clk_stopped & idle_stat & !busy_q;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic                 boot_en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 phase_sel,
    input  logic                 eng_idle,
    input  logic                 xfer_busy,
    output logic                 sclk,
    output logic                 clk_stopped,
    output logic                 idle_stat,
    output logic                 cfg_safe
);

    clk_cfg_t             cfg_q;
    clk_cfg_t             cfg_d;
    cnt_t                 cnt_q;
    cnt_t                 cnt_d;
    logic                 running_q;
    logic                 running_d;
    logic                 base_q;
    logic [DIV_SEL_W-1:0] cfg_div;
    logic                 cfg_ph;

    sclk_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .run_req   (run_en | boot_en),
        .div_sel   (div_sel),
        .phase_sel (phase_sel),
        .cfg_q     (cfg_q),
        .cfg_d     (cfg_d),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .running_q (running_q),
        .running_d (running_d)
    );

    sclk_shape #(.HALF_SHIFT_EN(1'b1)) i_shape (
        .clk       (clk),
        .rst       (rst),
        .running_q (running_q),
        .running_d (running_d),
        .cfg_q     (cfg_q),
        .cfg_d     (cfg_d),
        .cnt_d     (cnt_d),
        .base_q    (base_q),
        .sclk      (sclk)
    );

    sclk_status i_status (
        .clk         (clk),
        .rst         (rst),
        .running_q   (running_q),
        .eng_idle    (eng_idle),
        .xfer_busy   (xfer_busy),
        .clk_stopped (clk_stopped),
        .idle_stat   (idle_stat),
        .cfg_safe    (cfg_safe)
    );

    assign cfg_div = cfg_q.div;
    assign cfg_ph  = cfg_q.ph;

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
    import sclk_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 run_en,
    input logic                 boot_en,
    input logic                 running_q,
    input cnt_t                 cnt_q,
    input logic [DIV_SEL_W-1:0] cfg_div,
    input logic                 cfg_ph,
    input logic                 clk_stopped,
    input logic                 base_q
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!running_q && (run_en || boot_en)) |=> running_q);

    p_hold_any_enable_r3: assert property (@(posedge clk) disable iff (rst)
        (running_q && (run_en || boot_en)) |=> running_q);

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        running_q |-> (cnt_q <= last_cnt(cfg_div)));

    p_stop_at_period_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(running_q) |-> ($past(cnt_q) == last_cnt($past(cfg_div))));

    p_parked_low_r7: assert property (@(posedge clk) disable iff (rst)
        clk_stopped |-> (cnt_q == '0 && !base_q));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (running_q && $past(running_q)) |-> ($stable(cfg_div) && $stable(cfg_ph)));

endmodule

bind sclk_gen sclk_gen_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .boot_en     (boot_en),
    .running_q   (running_q),
    .cnt_q       (cnt_q),
    .cfg_div     (cfg_div),
    .cfg_ph      (cfg_ph),
    .clk_stopped (clk_stopped),
    .base_q      (base_q)
);

// File: tb/test_sclk_gen.sv
module test_sclk_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic       boot_en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       phase_sel = 1'b0;
    logic       eng_idle = 1'b0;
    logic       xfer_busy = 1'b0;
    logic       sclk;
    logic       clk_stopped;
    logic       idle_stat;
    logic       cfg_safe;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sclk_gen i_sclk_gen (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .boot_en     (boot_en),
        .div_sel     (div_sel),
        .phase_sel   (phase_sel),
        .eng_idle    (eng_idle),
        .xfer_busy   (xfer_busy),
        .sclk        (sclk),
        .clk_stopped (clk_stopped),
        .idle_stat   (idle_stat),
        .cfg_safe    (cfg_safe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic half_step();
        @(negedge clk);
        #2;
    endtask

    function automatic logic exp_high(input int j, input int n, input logic ph);
        int c;
        c = j % n;
        if (ph && n >= 4) c = (j + n / 4) % n;
        return c >= n / 2;
    endfunction

    task automatic go_idle();
        run_en  = 1'b0;
        boot_en = 1'b0;
        repeat (12) step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 clk_stopped", clk_stopped, 1'b1);
        chk("R1 idle_stat", idle_stat, 1'b0);
        chk("R1 cfg_safe", cfg_safe, 1'b0);
    endtask

    task automatic t_divided(input logic [1:0] d, input logic ph);
        int n;
        n = 1 << d;
        go_idle();
        div_sel   = d;
        phase_sel = ph;
        step();
        run_en = 1'b1;
        for (int j = 0; j < 3 * n; j++) begin
            step();
            if (j == 0) chk("R2 stopped on start edge", clk_stopped, 1'b1);
            if (j == 1) chk("R2 stopped cleared", clk_stopped, 1'b0);
            chk(ph ? "R6 shifted waveform" : "R4 divided waveform", sclk, exp_high(j, n, ph));
        end
        go_idle();
    endtask

    task automatic t_bypass();
        go_idle();
        div_sel   = 2'd0;
        phase_sel = 1'b1;
        step();
        run_en = 1'b1;
        step();
        for (int j = 1; j <= 4; j++) begin
            step();
            chk("R5 bypass high phase", sclk, 1'b1);
            half_step();
            chk("R5 bypass low phase", sclk, 1'b0);
        end
        run_en = 1'b0;
        step();
        step();
        chk("R5 bypass gated off", sclk, 1'b0);
        half_step();
        chk("R5 bypass gated off low", sclk, 1'b0);
        go_idle();
    endtask

    task automatic t_half_shift();
        go_idle();
        div_sel   = 2'd1;
        phase_sel = 1'b1;
        step();
        run_en = 1'b1;
        for (int j = 0; j < 8; j++) begin
            step();
            if (j >= 1) chk("R6 half shift at rise", sclk, (j % 2) == 0);
            half_step();
            chk("R6 half shift at fall", sclk, (j % 2) == 1);
        end
        go_idle();
    endtask

    task automatic t_stop_point();
        go_idle();
        div_sel   = 2'd2;
        phase_sel = 1'b0;
        step();
        run_en = 1'b1;
        repeat (6) step();
        run_en = 1'b0;
        step();
        chk("R7 period continues", sclk, 1'b1);
        step();
        chk("R7 period continues", sclk, 1'b1);
        chk("R7 not yet stopped", clk_stopped, 1'b0);
        step();
        chk("R7 parked low", sclk, 1'b0);
        chk("R7 status lags stop", clk_stopped, 1'b0);
        step();
        chk("R7 stopped status", clk_stopped, 1'b1);
        chk("R7 still low", sclk, 1'b0);
    endtask

    task automatic t_two_enables();
        int highs;
        go_idle();
        div_sel   = 2'd1;
        phase_sel = 1'b0;
        step();
        run_en  = 1'b1;
        boot_en = 1'b1;
        repeat (4) step();
        run_en = 1'b0;
        highs  = 0;
        for (int j = 0; j < 10; j++) begin
            step();
            chk("R3 one enable keeps running", clk_stopped, 1'b0);
            if (sclk) highs++;
        end
        chk("R3 clock still toggles", highs > 0, 1'b1);
        boot_en = 1'b0;
        repeat (4) step();
        chk("R3 stops when both clear", clk_stopped, 1'b1);
        boot_en = 1'b1;
        step();
        step();
        chk("R2 start with boot enable", clk_stopped, 1'b0);
        go_idle();
    endtask

    task automatic t_cfg_hold();
        go_idle();
        div_sel   = 2'd2;
        phase_sel = 1'b0;
        step();
        run_en = 1'b1;
        step();
        div_sel = 2'd3;
        for (int j = 1; j < 12; j++) begin
            step();
            chk("R8 divide held while running", sclk, exp_high(j, 4, 1'b0));
        end
        go_idle();
        run_en = 1'b1;
        for (int j = 0; j < 16; j++) begin
            step();
            chk("R8 new divide after restart", sclk, exp_high(j, 8, 1'b0));
        end
        go_idle();
    endtask

    task automatic t_status();
        go_idle();
        eng_idle  = 1'b0;
        xfer_busy = 1'b0;
        step();
        chk("R9 idle low", idle_stat, 1'b0);
        chk("R10 unsafe when busy engine", cfg_safe, 1'b0);
        eng_idle = 1'b1;
        chk("R9 one cycle latency", idle_stat, 1'b0);
        step();
        chk("R9 idle follows", idle_stat, 1'b1);
        chk("R10 safe", cfg_safe, 1'b1);
        xfer_busy = 1'b1;
        step();
        chk("R10 bus transfer blocks", cfg_safe, 1'b0);
        xfer_busy = 1'b0;
        step();
        chk("R10 safe again", cfg_safe, 1'b1);
        run_en = 1'b1;
        step();
        step();
        chk("R10 unsafe while running", cfg_safe, 1'b0);
        eng_idle = 1'b0;
        step();
        chk("R9 idle drops", idle_stat, 1'b0);
        go_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_divided(2'd1, 1'b0);
        t_divided(2'd2, 1'b0);
        t_divided(2'd3, 1'b0);
        t_divided(2'd2, 1'b1);
        t_divided(2'd3, 1'b1);
        t_bypass();
        t_half_shift();
        t_stop_point();
        t_two_enables();
        t_cfg_hold();
        t_status();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule